// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block turns a processor access that falls inside a configuration window into a conventional PCI configuration address. It is a single pipeline stage. It takes three inputs:

- the low 16 bits of the window offset,
- a 32-bit programmable map register,
- the number of the bus being addressed.

It joins the offset and the low half of the map register into one 32-bit working word. The upper part of that word, bits 31:11, is a one-hot device-select field. The block turns it into a device number by finding its lowest set bit. It also extracts the function and register fields, then packs all of them with the bus number and an enable bit.

Each request strobe gives exactly one of three outcomes one cycle later:

- **Valid:** a pulse on `addr_vld` together with a fresh address.
- **Error:** a pulse on `sel_err`, because the select field was empty.
- **Unsupported:** a pulse on `unsup`, because the map register asks for a mode this block does not handle (type-1 accesses). For an unsupported read, the block also supplies a fill value of all ones, sized to the access width. An unsupported write is dropped.

Byte, halfword and word accesses are all translated. Running the PCI transaction itself is left to the logic that consumes `cfg_addr`.

Top module: `pci_cfg_xlate`

## Requirements
- R1: After reset, `addr_vld`, `sel_err` and `unsup` are 0, and `cfg_addr` and `fill_data` are 0.
- R2: The working word is built as follows: bits 15:0 are `offset`, and bits 31:16 are `map_reg[15:0]`.
- R3: The device number placed in `cfg_addr[15:11]` is the index, counted from working-word bit 11, of the lowest set bit in working-word bits 31:11.
- R4: `cfg_addr[10:8]` equals working-word bits 10:8 (function), `cfg_addr[7:2]` equals working-word bits 7:2 (register), and `cfg_addr[1:0]` is 0.
- R5: On a valid translation, `cfg_addr[23:16]` equals `bus_num`, `cfg_addr[31]` is 1 and `cfg_addr[30:24]` is 0.
- R6: When `map_reg[16]` is 1, the request does not raise `addr_vld`, and it leaves `cfg_addr` unchanged.
  - `unsup` pulses instead.
  - For a read (`is_wr`=0), `fill_data` becomes all ones of the access width. `size` 0 gives 0x000000FF, `size` 1 gives 0x0000FFFF, and `size` 2 or 3 gives 0xFFFFFFFF.
  - For a write, `fill_data` becomes 0.
- R7: When `map_reg[16]` is 0 and working-word bits 31:11 are all zero, `sel_err` pulses for one cycle. `addr_vld` stays 0 and `cfg_addr` is left unchanged.
- R8: All outputs take their new value in the cycle after `req` is sampled high. `addr_vld`, `sel_err` and `unsup` are one-cycle pulses, and at most one of them is high at a time.
- R9: A valid translation is produced for every `size` value, and `fill_data` is 0 on any request that is not an unsupported read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, one cycle per access |
| is_wr | input | 1 | 1 = write access, 0 = read access |
| size | input | 2 | Access width: 0 byte, 1 halfword, 2 or 3 word |
| offset | input | 16 | Low bits of the window offset |
| map_reg | input | 32 | Map register: bits 15:0 upper address, bit 16 unsupported-mode bit |
| bus_num | input | 8 | Bus number to place in the address |
| cfg_addr | output | 32 | Composed configuration address with enable in bit 31 |
| addr_vld | output | 1 | Pulse: `cfg_addr` holds a new valid address |
| sel_err | output | 1 | Pulse: device-select field was zero |
| unsup | output | 1 | Pulse: access rejected by the mode bit |
| fill_data | output | 32 | All-ones read value for an unsupported read |

## Verification
The device-number decode is driven three ways:

- a random one-hot select placed anywhere in the 21-bit field;
- several random bits set together, which shows that the lowest bit wins over the higher ones;
- the two ends, select bit 0 in the offset and bit 20 in the map register, which shows that both halves of the working word feed the field.

A random mix of read and write, the three widths and the mode bit separates the unsupported path from the normal one. The fill value checks each width's mask. An all-zero select and a dropped write are followed by a check that `cfg_addr` kept its earlier value. Idle cycles after every request confirm that the pulses last only one cycle.

// File: rtl/pci_cfg_xlate.sv
module pci_cfg_xlate #(
  parameter int OFS_W = 16,
  parameter int BUS_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        is_wr,
  input  logic [1:0]  size,
  input  logic [OFS_W-1:0] offset,
  input  logic [31:0] map_reg,
  input  logic [BUS_W-1:0] bus_num,
  output logic [31:0] cfg_addr,
  output logic        addr_vld,
  output logic        sel_err,
  output logic        unsup,
  output logic [31:0] fill_data
);
  localparam int SEL_LO = 11;
  localparam int SEL_W  = 32 - SEL_LO;
  localparam int MODE_BIT = 16;

  logic [31:0]      word;
  logic [SEL_W-1:0] sel;
  logic [4:0]       dev;
  logic [31:0]      mask;
  logic             bad_mode, no_sel;

  assign word     = {map_reg[31-OFS_W:0], offset};
  assign sel      = word[31:SEL_LO];
  assign bad_mode = map_reg[MODE_BIT];
  assign no_sel   = (sel == '0);

  always_comb begin
    dev = '0;
    for (int i = SEL_W-1; i >= 0; i--)
      if (sel[i]) dev = 5'(i);
  end

  always_comb begin
    case (size)
      2'd0:    mask = 32'h0000_00FF;
      2'd1:    mask = 32'h0000_FFFF;
      default: mask = 32'hFFFF_FFFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_addr  <= '0;
      addr_vld  <= 1'b0;
      sel_err   <= 1'b0;
      unsup     <= 1'b0;
      fill_data <= '0;
    end else begin
      addr_vld <= 1'b0;
      sel_err  <= 1'b0;
      unsup    <= 1'b0;
      if (req) begin
        fill_data <= (bad_mode && !is_wr) ? mask : '0;
        if (bad_mode) begin
          unsup <= 1'b1;
        end else if (no_sel) begin
          sel_err <= 1'b1;
        end else begin
          addr_vld <= 1'b1;
          cfg_addr <= {1'b1, 7'b0, 8'(bus_num), dev, word[10:8], word[7:2], 2'b00};
        end
      end
    end
  end

  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_vld, sel_err, unsup}));
  a_r8_pulse_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld || sel_err || unsup) |-> $past(req));
  a_r5_bus_and_enable: assert property (@(posedge clk) disable iff (!rst_n)
    req && !bad_mode && !no_sel |=> cfg_addr[31] && cfg_addr[30:24] == 7'd0
      && cfg_addr[23:16] == 8'($past(bus_num)));
  a_r6_mode_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    req && bad_mode |=> unsup && !addr_vld && $stable(cfg_addr));
  a_r7_err_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    req && !bad_mode && no_sel |=> sel_err && $stable(cfg_addr));
  a_r4_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |-> cfg_addr[1:0] == 2'b00);
endmodule

// File: tb/sim_pci_cfg_xlate.sv
module sim_pci_cfg_xlate;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0, req = 0, is_wr = 0;
  logic [1:0] size = 0;
  logic [15:0] offset = 0;
  logic [31:0] map_reg = 0;
  logic [7:0] bus_num = 0;
  logic [31:0] cfg_addr, fill_data;
  logic addr_vld, sel_err, unsup;
  int checks = 0, fails = 0;
  logic [31:0] last_addr = 0;

  pci_cfg_xlate u0 (.clk, .rst_n, .req, .is_wr, .size, .offset, .map_reg,
    .bus_num, .cfg_addr, .addr_vld, .sel_err, .unsup, .fill_data);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [15:0] o, input logic [31:0] m, input logic [7:0] b);
    logic [31:0] w = {m[15:0], o};
    logic [4:0] d = 0;
    for (int i = 20; i >= 0; i--) if (w[11+i]) d = 5'(i);
    return {1'b1, 7'd0, b, d, w[10:8], w[7:2], 2'b00};
  endfunction

  function automatic logic [31:0] exp_fill(input logic [1:0] s);
    return s == 0 ? 32'hFF : s == 1 ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic access(input logic w, input logic [1:0] s, input logic [15:0] o,
                        input logic [31:0] m, input logic [7:0] b);
    logic mode_bad = m[16];
    logic zero_sel = ({m[15:0], o[15:11]} == 0);
    @(negedge clk);
    req = 1; is_wr = w; size = s; offset = o; map_reg = m; bus_num = b;
    @(negedge clk);
    req = 0;
    if (mode_bad) begin
      chk("R6 unsup", {31'd0, unsup}, 1);
      chk("R6 no vld", {31'd0, addr_vld}, 0);
      chk("R6 addr held", cfg_addr, last_addr);
      chk("R6 fill", fill_data, w ? 32'd0 : exp_fill(s));
    end else if (zero_sel) begin
      chk("R7 err", {31'd0, sel_err}, 1);
      chk("R7 no vld", {31'd0, addr_vld}, 0);
      chk("R7 addr held", cfg_addr, last_addr);
    end else begin
      chk("R8 vld", {29'd0, addr_vld, sel_err, unsup}, 4);
      chk("R2 R3 R4 R5 addr", cfg_addr, exp_addr(o, m, b));
      chk("R9 fill zero", fill_data, 0);
      last_addr = cfg_addr;
    end
    @(negedge clk);
    chk("R8 pulse ends", {29'd0, addr_vld, sel_err, unsup}, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(PERIOD*2 + 1);
    chk("R1 addr", cfg_addr, 0);
    chk("R1 pulses", {29'd0, addr_vld, sel_err, unsup}, 0);
    chk("R1 fill", fill_data, 0);
    rst_n = 1;
    access(0, 2, 16'h0800 | 16'h0234, 32'h0, 8'h3C);
    access(0, 0, 16'h00FC, 32'h0000_8000, 8'h01);
    access(1, 1, 16'h0ABC | 16'hF800, 32'h0000_FFF0, 8'hA5);
    access(0, 1, 16'h0700, 32'h0, 8'h11);
    access(0, 0, 16'h1234, 32'h0001_0040, 8'h22);
    access(0, 1, 16'h1234, 32'h0001_0040, 8'h22);
    access(0, 3, 16'h1234, 32'h0001_0040, 8'h22);
    access(1, 2, 16'h1234, 32'h0001_0040, 8'h22);
    for (int n = 0; n < 300; n++) begin
      logic [31:0] m = $urandom;
      logic [15:0] o = 16'($urandom);
      int k = $urandom_range(0, 20);
      if (n % 3 == 0) begin
        logic [20:0] oh = 21'(1) << k;
        o[15:11] = oh[4:0];
        m[15:0] = oh[20:5];
      end
      if (n % 5 != 0) m[16] = 0;
      if (n % 17 == 0) begin o[15:11] = 0; m[15:0] = 0; end
      access(1'($urandom), 2'($urandom), o, m, 8'($urandom));
    end
    repeat (3) @(negedge clk);
    chk("R8 idle", {29'd0, addr_vld, sel_err, unsup}, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule